// File: doc/BRIEF.md
# Streaming Sobel Edge Overlay

This block is a per-pixel video filter. It sits in a stream of 24-bit YUV444 words and keeps only the luma byte of each one. It runs a 3x3 Sobel gradient over the luma and turns each gradient into a hard decision: full white (255) where the gradient is strong, black (0) where it is not. That decision is then mixed with the original luma of the same pixel using a programmable weight. The mixed luma goes back out in a 24-bit word whose two chroma bytes are forced to mid-scale. The result is a grey picture with highlighted edges.

Two settings are written through a small write port: the mix weight (alpha) and the gradient threshold. Both stream sides use valid/ready. A word moves on a side only in a cycle where valid and ready are both high. The output holds its word unchanged while the consumer withholds ready. The input is refused (`s_tready` low) exactly when the output holds a word that is not being taken. No pixel is dropped or duplicated. The pipeline has a fixed depth of three advancing cycles, and the start-of-frame and end-of-line markers travel with their pixel.

The 3x3 window trails the incoming pixel. The window for pixel (r, c) spans rows r-2..r and columns c-2..c. Any position above the frame top or left of the first column takes the nearest pixel inside the frame. Frames up to `MAX_W` pixels wide are supported (1920 by default). The frame height is set only by the markers.

Top module: `edge_overlay`

## Requirements
- R1: After reset, `m_tvalid` is low and `s_tready` is high. Alpha is 0 and the threshold is 128 until they are written.
- R2: Every output word carries the result luma in bits 7:0 and 0x80 in bits 15:8 and in bits 23:16. Input bits 23:8 have no effect on any output.
- R3: With G = |Gx| + |Gy|, a pixel is an edge (edge value 255) when G is strictly greater than the threshold, and a non-edge (edge value 0) otherwise. The terms are: Gx = (T+2M+B at column c) - (T+2M+B at column c-2), and Gy = (L+2C+R of row r) - (L+2C+R of row r-2). Here T/M/B are rows r-2/r-1/r and L/C/R are columns c-2/c-1/c.
- R4: Window positions with a row index below 0 use row 0, and positions with a column index below 0 use column 0. This holds even for frames that are one pixel wide.
- R5: The output luma is round((alpha*E + (255-alpha)*Y) / 255), where E is the edge value and Y is the input luma of the same pixel. The result stays within 0..255.
- R6: With alpha 0, the output luma equals the input luma exactly.
- R7: Output words leave in input order, one for each accepted input word. `m_tuser` and `m_tlast` equal the `s_tuser` and `s_tlast` that came with that pixel.
- R8: While `m_tvalid` is high and `m_tready` is low, `s_tready` is low, and `m_tvalid`, `m_tdata`, `m_tuser` and `m_tlast` stay unchanged on the next cycle.
- R9: A word with `s_tuser` high is row 0, column 0 of a new frame, and no earlier frame's rows reach its window. The word after one with `s_tlast` high starts column 0 of the next row.
- R10: A cycle with `cfg_we` high writes `cfg_wdata[7:0]` to alpha when `cfg_sel` is 0, and `cfg_wdata[10:0]` to the threshold when `cfg_sel` is 1. The new value is in place on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | 24 | Input YUV444 word, luma in bits 7:0 |
| s_tvalid | input | 1 | Input word valid |
| s_tready | output | 1 | Block can take a word |
| s_tuser | input | 1 | Input start of frame |
| s_tlast | input | 1 | Input end of line |
| m_tdata | output | 24 | Output word, chroma forced to 0x80 |
| m_tvalid | output | 1 | Output word valid |
| m_tready | input | 1 | Consumer takes the word |
| m_tuser | output | 1 | Output start of frame |
| m_tlast | output | 1 | Output end of line |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 1 | 0 selects alpha, 1 selects threshold |
| cfg_wdata | input | 11 | Setting value |

## Verification
The hardest case to reach is a consumer stall that lands while several pixels sit inside the pipeline and the frame is crossing a row or frame boundary. In that case the window update and the hold of the output must not lose a pixel or shift one into the wrong column. The bench reaches this case with random gaps on the input, a random `m_tready` on filtered frames, and frames of several widths, including one that is a single pixel wide. A reference model, written independently of the design, predicts every output word from the requirements.

// File: rtl/edge_overlay_pkg.sv
package edge_overlay_pkg;
  localparam int PIX_W = 8;
  localparam int MAG_W = 11;
  localparam logic [PIX_W-1:0] CHROMA_MID = 8'h80;
  localparam logic [PIX_W-1:0] LUMA_FULL = 8'hFF;

  typedef logic [PIX_W-1:0] pix_t;
  // [0] current row, [1] row above, [2] two rows above
  typedef pix_t [2:0] colv_t;
  // [0] newest column, [2] oldest column
  typedef colv_t [2:0] win_t;
endpackage

// File: rtl/eo_window.sv
module eo_window
  import edge_overlay_pkg::*;
#(
  parameter int MAX_W = 1920
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift,
  input  pix_t pix,
  input  logic sof,
  input  logic eol,
  output win_t win
);
  localparam int CW = $clog2(MAX_W);
  localparam int NLB = 2;

  logic [CW-1:0] col_q, col_in;
  logic [1:0] row_q, row_in;
  pix_t lb [NLB][MAX_W];
  colv_t vert;

  assign col_in = sof ? '0 : col_q;
  assign row_in = sof ? 2'd0 : row_q;

  assign vert[0] = pix;
  for (genvar k = 1; k <= NLB; k++) begin : g_tap
    // rows above the frame top repeat the nearest row inside it
    assign vert[k] = (row_in >= 2'(k)) ? lb[k-1][col_in] : vert[k-1];
  end

  always_ff @(posedge clk) begin
    if (shift) begin
      lb[0][col_in] <= pix;
      lb[1][col_in] <= lb[0][col_in];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (shift) begin
      if (eol) begin
        col_q <= '0;
        row_q <= (row_in == 2'd2) ? 2'd2 : row_in + 2'd1;
      end else begin
        col_q <= (col_in == CW'(MAX_W - 1)) ? col_in : col_in + 1'b1;
        row_q <= row_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win <= '0;
    end else if (shift) begin
      if (col_in == '0) win <= {vert, vert, vert};
      else              win <= {win[1], win[0], vert};
    end
  end
endmodule

// File: rtl/eo_sobel.sv
module eo_sobel
  import edge_overlay_pkg::*;
(
  input  win_t             win,
  input  logic [MAG_W-1:0] thresh,
  output logic             hit
);
  logic [9:0] csum [3];
  logic [9:0] rsum_bot, rsum_top;
  logic [9:0] ax, ay;
  logic [MAG_W-1:0] mag;

  for (genvar j = 0; j < 3; j++) begin : g_col
    assign csum[j] = {2'b0, win[j][2]} + {1'b0, win[j][1], 1'b0} + {2'b0, win[j][0]};
  end

  assign rsum_bot = {2'b0, win[2][0]} + {1'b0, win[1][0], 1'b0} + {2'b0, win[0][0]};
  assign rsum_top = {2'b0, win[2][2]} + {1'b0, win[1][2], 1'b0} + {2'b0, win[0][2]};

  assign ax = (csum[0] >= csum[2]) ? csum[0] - csum[2] : csum[2] - csum[0];
  assign ay = (rsum_bot >= rsum_top) ? rsum_bot - rsum_top : rsum_top - rsum_bot;
  assign mag = {1'b0, ax} + {1'b0, ay};
  assign hit = mag > thresh;
endmodule

// File: rtl/eo_blend.sv
module eo_blend
  import edge_overlay_pkg::*;
(
  input  logic [7:0] alpha,
  input  logic       hit,
  input  pix_t       luma,
  output pix_t       y
);
  logic [7:0]  ev;
  logic [15:0] s;
  logic [16:0] t, q;

  always_comb begin
    ev = hit ? LUMA_FULL : '0;
    s  = 16'(alpha) * 16'(ev) + 16'(8'hFF - alpha) * 16'(luma);
    // rounded division by 255 using two shifts
    t  = {1'b0, s} + 17'd128;
    q  = (t + (t >> 8)) >> 8;
    y  = (q > 17'd255) ? 8'hFF : q[7:0];
  end
endmodule

// File: rtl/edge_overlay.sv
module edge_overlay
  import edge_overlay_pkg::*;
#(
  parameter int MAX_W = 1920
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] s_tdata,
  input  logic        s_tvalid,
  output logic        s_tready,
  input  logic        s_tuser,
  input  logic        s_tlast,
  output logic [23:0] m_tdata,
  output logic        m_tvalid,
  input  logic        m_tready,
  output logic        m_tuser,
  output logic        m_tlast,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [10:0] cfg_wdata
);
  localparam logic [MAG_W-1:0] THR_RESET = MAG_W'(128);

  logic [7:0]       alpha_q;
  logic [MAG_W-1:0] thr_q;
  logic             en, acc;
  logic             v1, u1, l1, v2, u2, l2, e2;
  pix_t             y1, y2, yb;
  win_t             win;
  logic             hit;

  assign en       = m_tready | ~m_tvalid;
  assign s_tready = en;
  assign acc      = en & s_tvalid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alpha_q <= '0;
      thr_q   <= THR_RESET;
    end else if (cfg_we) begin
      if (cfg_sel) thr_q <= cfg_wdata;
      else         alpha_q <= cfg_wdata[7:0];
    end
  end

  eo_window #(.MAX_W(MAX_W)) u_win (
    .clk(clk), .rst_n(rst_n), .shift(acc), .pix(s_tdata[PIX_W-1:0]),
    .sof(s_tuser), .eol(s_tlast), .win(win)
  );

  eo_sobel u_sobel (.win(win), .thresh(thr_q), .hit(hit));

  eo_blend u_blend (.alpha(alpha_q), .hit(e2), .luma(y2), .y(yb));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {v1, u1, l1, y1} <= '0;
      {v2, u2, l2, y2, e2} <= '0;
      m_tvalid <= 1'b0;
      m_tuser  <= 1'b0;
      m_tlast  <= 1'b0;
      m_tdata  <= '0;
    end else if (en) begin
      v1 <= s_tvalid;
      u1 <= s_tuser;
      l1 <= s_tlast;
      y1 <= s_tdata[PIX_W-1:0];
      v2 <= v1;
      u2 <= u1;
      l2 <= l1;
      y2 <= y1;
      e2 <= hit;
      m_tvalid <= v2;
      m_tuser  <= u2;
      m_tlast  <= l2;
      m_tdata  <= {CHROMA_MID, CHROMA_MID, yb};
    end
  end
endmodule

// File: rtl/eo_checker.sv
module eo_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        s_tready,
  input logic [23:0] m_tdata,
  input logic        m_tvalid,
  input logic        m_tready,
  input logic        m_tuser,
  input logic        m_tlast,
  input logic        cfg_we,
  input logic        cfg_sel,
  input logic [10:0] cfg_wdata,
  input logic [7:0]  alpha_q,
  input logic [10:0] thr_q
);
  p_chroma_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> m_tdata[23:8] == 16'h8080);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast));

  p_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |-> !s_tready);

  p_thr_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_sel |=> thr_q == $past(cfg_wdata));

  p_alpha_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_sel |=> alpha_q == $past(cfg_wdata[7:0]));
endmodule

bind edge_overlay eo_checker i_chk (
  .clk(clk), .rst_n(rst_n), .s_tready(s_tready), .m_tdata(m_tdata),
  .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tuser(m_tuser), .m_tlast(m_tlast),
  .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .alpha_q(alpha_q), .thr_q(thr_q)
);

// File: tb/test_edge_overlay.sv
module test_edge_overlay;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [23:0] s_tdata = '0;
  logic s_tvalid = 1'b0, s_tuser = 1'b0, s_tlast = 1'b0, s_tready;
  logic [23:0] m_tdata;
  logic m_tvalid, m_tuser, m_tlast;
  logic m_tready = 1'b1;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [10:0] cfg_wdata = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  edge_overlay i_edge_overlay (
    .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .s_tuser(s_tuser), .s_tlast(s_tlast), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .m_tuser(m_tuser), .m_tlast(m_tlast),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata)
  );

  typedef struct {
    logic [23:0] d;
    logic u;
    logic l;
    int r;
    int c;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  int alpha_m = 0, thr_m = 128;
  int img [16][16];
  bit stall_on = 0, gaps_on = 0, mon_on = 0, done = 0;

  function automatic int px(int r, int c);
    return img[r < 0 ? 0 : r][c < 0 ? 0 : c];
  endfunction

  function automatic int absi(int v);
    return v < 0 ? -v : v;
  endfunction

  // reference model of R3, R4 and R5
  function automatic int model_luma(int r, int c);
    int gx, gy, e, s;
    gx = (px(r-2, c) + 2*px(r-1, c) + px(r, c)) - (px(r-2, c-2) + 2*px(r-1, c-2) + px(r, c-2));
    gy = (px(r, c-2) + 2*px(r, c-1) + px(r, c)) - (px(r-2, c-2) + 2*px(r-2, c-1) + px(r-2, c));
    e = (absi(gx) + absi(gy) > thr_m) ? 255 : 0;
    s = alpha_m * e + (255 - alpha_m) * px(r, c);
    return (2*s + 255) / 510;
  endfunction

  function automatic int pattern(int kind, int r, int c, int seed);
    case (kind)
      0: return (r*30 + c*20) % 256;
      1: return (c < 4) ? 10 : 200;
      2: return ((r*37 + c*91 + seed*13) ^ (r*c*7)) % 256;
      3: return ((r + c) % 2 == 1) ? 220 : 30;
      default: return 77;
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(bit sel, int val);
    cfg_we = 1'b1;
    cfg_sel = sel;
    cfg_wdata = 11'(val);
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    if (sel) thr_m = val; else alpha_m = val & 255;
  endtask

  task automatic send_px(logic [23:0] d, logic u, logic l);
    s_tdata = d;
    s_tuser = u;
    s_tlast = l;
    s_tvalid = 1'b1;
    @(negedge clk);
    while (!s_tready) @(negedge clk);
    @(posedge clk);
    #1;
    s_tvalid = 1'b0;
  endtask

  task automatic run_frame(int w, int h, int kind, int seed, string tag);
    exp_t it;
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) img[r][c] = pattern(kind, r, c, seed);
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        it.d = {16'h8080, 8'(model_luma(r, c))};
        it.u = (r == 0 && c == 0);
        it.l = (c == w - 1);
        it.r = r;
        it.c = c;
        it.tag = tag;
        q.push_back(it);
        send_px({16'($urandom), 8'(img[r][c])}, it.u, it.l);
        if (gaps_on && ($urandom % 3 == 0)) begin
          repeat (1 + $urandom % 2) @(posedge clk);
          #1;
        end
      end
    end
  endtask

  task automatic drain();
    int n = 0;
    while ((q.size() != 0 || m_tvalid) && n < 2000) begin
      @(posedge clk);
      n++;
    end
    #1;
    check(q.size() == 0, "R7", "words still owed after drain", q.size(), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // consumer ready
  initial begin
    forever begin
      @(posedge clk);
      #1;
      m_tready = stall_on ? ($urandom % 4 != 0) : 1'b1;
    end
  end

  // scoreboard monitor and stall checks (R7, R8)
  initial begin
    exp_t it;
    bit prev_stall = 0;
    logic [23:0] prev_d = '0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (prev_stall) begin
          check(m_tvalid && m_tdata == prev_d, "R8", "held word changed during stall", int'(m_tdata), int'(prev_d));
        end
        if (m_tvalid && !m_tready) begin
          check(!s_tready, "R8", "s_tready during stall", int'(s_tready), 0);
        end
        if (m_tvalid && m_tready) begin
          if (q.size() == 0) begin
            check(0, "R7", "unexpected output word", int'(m_tdata), -1);
          end else begin
            it = q.pop_front();
            check(m_tdata == it.d, it.tag, $sformatf("data at (%0d,%0d)", it.r, it.c), int'(m_tdata), int'(it.d));
            check(m_tuser == it.u && m_tlast == it.l, "R7",
                  $sformatf("user/last at (%0d,%0d)", it.r, it.c),
                  int'({m_tuser, m_tlast}), int'({it.u, it.l}));
          end
        end
        prev_stall = m_tvalid && !m_tready;
        prev_d = m_tdata;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(m_tvalid == 1'b0, "R1", "m_tvalid in reset", int'(m_tvalid), 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(m_tvalid == 1'b0, "R1", "m_tvalid after reset", int'(m_tvalid), 0);
    check(s_tready == 1'b1, "R1", "s_tready after reset", int'(s_tready), 1);
    mon_on = 1;
    @(posedge clk);
    #1;

    // default alpha 0: plain pass of luma, upper input bits random (R1 R2 R6)
    run_frame(8, 5, 0, 0, "R1 R2 R6");
    drain();

    // default threshold 128, full edge weight (R1 R3 R4)
    cfg_write(0, 255);
    run_frame(8, 5, 1, 0, "R1 R3 R4");
    drain();

    // higher threshold, new narrower frame (R3 R4 R9 R10)
    cfg_write(1, 300);
    run_frame(7, 6, 2, 3, "R3 R4 R9 R10");
    drain();

    // partial blend with stalls and input gaps (R5 R8)
    cfg_write(0, 100);
    cfg_write(1, 60);
    stall_on = 1;
    gaps_on = 1;
    run_frame(6, 4, 3, 0, "R5 R8");
    drain();

    // alpha back to zero under stalls (R6 R8)
    cfg_write(0, 0);
    run_frame(9, 5, 2, 11, "R6 R8");
    drain();

    // one pixel wide frame: every word is column 0 and end of line (R4 R9)
    cfg_write(0, 180);
    cfg_write(1, 20);
    run_frame(1, 5, 2, 5, "R4 R9");
    drain();

    // maximum threshold never flags an edge (R3 R5 R10)
    cfg_write(0, 200);
    cfg_write(1, 2040);
    stall_on = 0;
    gaps_on = 0;
    run_frame(5, 3, 3, 0, "R3 R5 R10");
    drain();

    // zero threshold on flat image: zero gradient is not an edge (R3 R5)
    cfg_write(0, 128);
    cfg_write(1, 0);
    run_frame(4, 4, 9, 0, "R3 R5");
    drain();

    // zero threshold on varying image marks edges (R3 R5 R9)
    run_frame(10, 4, 2, 7, "R3 R5 R9");
    drain();

    finish_run();
  end
endmodule